// File: doc/BRIEF.md
# Craps Game Controller

This block is the control core of a two-dice craps game. An external dice generator supplies the current sum of the two dice and three decode flags for it. The controller runs the game's two phases: an opening roll settled by the natural and craps sums, then any number of follow-up rolls compared against a stored point. It keeps the point internally and makes its own equality test against the incoming sum. It drives an enable for the dice counters, a one-cycle store strobe for the point, and separate win and lose indications that stay lit until the game is reset.

Every roll is a press followed by a release of the roll button. The outcome is judged on the clock edge after the release is sampled, so the dice counters have stopped and the sum is settled. Two saturating tallies count won and lost games. They use their own system reset, so a game reset starts a new game without losing the score. Both resets are asynchronous and active-low, and each is released synchronously inside the block.

Top module: `craps_ctrl`

## Requirements
- R1: On the opening roll, when `sum_natural` is high (sum 7 or 11), `win` goes high on the clock edge after the evaluation cycle and `lose` stays low.
- R2: On the opening roll, when `sum_craps` is high (sum 2, 3 or 12) and `sum_natural` is low, `lose` goes high on the edge after the evaluation cycle and `win` stays low.
- R3: On the opening roll, any other sum raises `store_pt` for exactly the one evaluation cycle, loads that sum as the point, and produces neither `win` nor `lose`.
- R4: On a follow-up roll, a sum equal to the stored point sets `win`.
- R5: On a follow-up roll, a sum that is not the point but has `sum_seven` high sets `lose`; any other follow-up sum leaves both outputs low, raises no `store_pt`, and keeps the point.
- R6: On follow-up rolls, `sum_natural` and `sum_craps` are ignored (a later 11 or 2 that is not the point only continues the game); on the opening roll, `sum_seven` alone decides nothing.
- R7: `roll_en` equals `roll_btn` while the game waits for or holds a roll, and is 0 in the evaluation cycle and after the game has ended.
- R8: `win` and `lose` are never high together; once one is set, it holds, and pressing the roll button has no effect until a game reset.
- R9: Driving `game_rst_n` low clears `win`, `lose` and `store_pt` at once, without a clock, and the next roll after its release is treated as an opening roll.
- R10: `win_count` and `loss_count` each rise by one per game won or lost, saturate at 9, and are unaffected by `game_rst_n`.
- R11: Driving `sys_rst_n` low clears both counts and also resets the game.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | Asynchronous active-low system reset: clears tallies and game |
| game_rst_n | input | 1 | Asynchronous active-low game reset: returns to the opening roll |
| roll_btn | input | 1 | Debounced roll button, high while pressed |
| dice_sum | input | 4 | Current sum of the two dice, 2 to 12 |
| sum_seven | input | 1 | High when the sum is 7 |
| sum_natural | input | 1 | High when the sum is 7 or 11 |
| sum_craps | input | 1 | High when the sum is 2, 3 or 12 |
| roll_en | output | 1 | Enable for the dice counters |
| store_pt | output | 1 | One-cycle strobe that loads the point |
| win | output | 1 | Game won, held until game reset |
| lose | output | 1 | Game lost, held until game reset |
| win_count | output | 4 | Saturating count of games won |
| loss_count | output | 4 | Saturating count of games lost |

## Verification
A controller stuck in the wrong phase shows up on the next evaluation. If it is wrongly in the opening phase, a follow-up 11 or 2 gives a result instead of continuing. If it is wrongly in the follow-up phase, an opening 7 gives a loss. Either way the error appears at `win` or `lose` one edge after the release is sampled. A corrupted point is visible only when a later roll hits the true point value or the corrupted one. The bench therefore repeats the point with non-point rolls in between, and it watches `store_pt` in the exact evaluation cycle. A tally that mis-counts or wraps shows up at the count ports after the tenth game of one kind.

// File: rtl/craps_pkg.sv
package craps_pkg;

  typedef enum logic [2:0] {
    ST_OPEN_WAIT,
    ST_OPEN_HELD,
    ST_OPEN_EVAL,
    ST_NEXT_WAIT,
    ST_NEXT_HELD,
    ST_NEXT_EVAL,
    ST_WON,
    ST_LOST
  } game_st_e;

endpackage

// File: rtl/craps_rst_sync.sv
module craps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = shift_q[STAGES-1];

endmodule

// File: rtl/craps_point_reg.sv
module craps_point_reg #(
  parameter int SUM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SUM_W-1:0] sum,
  output logic             eq
);

  logic [SUM_W-1:0] point_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    point_q <= '0;
    else if (load) point_q <= sum;
  end

  assign eq = (sum == point_q);

endmodule

// File: rtl/craps_tally.sv
module craps_tally #(
  parameter int W   = 4,
  parameter int MAX = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] MAX_V = W'(MAX);

  logic [W-1:0] cnt_q;
  logic         cnt_en;

  assign cnt_en = inc && (cnt_q != MAX_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R10
  tally_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_V);

  // R10
  tally_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt_q));

endmodule

// File: rtl/craps_fsm.sv
module craps_fsm
  import craps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic roll_btn,
  input  logic is_nat,
  input  logic is_craps,
  input  logic is_seven,
  input  logic eq,
  output logic roll_en,
  output logic store_pt,
  output logic win,
  output logic lose,
  output logic win_evt,
  output logic lose_evt
);

  game_st_e st_q, st_d;
  logic     evaluating;

  always_comb begin
    st_d     = st_q;
    store_pt = 1'b0;
    unique case (st_q)
      ST_OPEN_WAIT: if (roll_btn)  st_d = ST_OPEN_HELD;
      ST_OPEN_HELD: if (!roll_btn) st_d = ST_OPEN_EVAL;
      ST_OPEN_EVAL: begin
        if (is_nat)        st_d = ST_WON;
        else if (is_craps) st_d = ST_LOST;
        else begin
          st_d     = ST_NEXT_WAIT;
          store_pt = 1'b1;
        end
      end
      ST_NEXT_WAIT: if (roll_btn)  st_d = ST_NEXT_HELD;
      ST_NEXT_HELD: if (!roll_btn) st_d = ST_NEXT_EVAL;
      ST_NEXT_EVAL: begin
        if (eq)            st_d = ST_WON;
        else if (is_seven) st_d = ST_LOST;
        else               st_d = ST_NEXT_WAIT;
      end
      ST_WON:  st_d = ST_WON;
      ST_LOST: st_d = ST_LOST;
      default: st_d = ST_OPEN_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OPEN_WAIT;
    else        st_q <= st_d;
  end

  assign evaluating = (st_q == ST_OPEN_EVAL) || (st_q == ST_NEXT_EVAL);
  assign roll_en    = roll_btn && (st_q inside {ST_OPEN_WAIT, ST_OPEN_HELD,
                                                ST_NEXT_WAIT, ST_NEXT_HELD});
  assign win        = (st_q == ST_WON);
  assign lose       = (st_q == ST_LOST);
  assign win_evt    = evaluating && (st_d == ST_WON);
  assign lose_evt   = evaluating && (st_d == ST_LOST);

  // R4
  point_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NEXT_EVAL && eq) |=> win);

  // R5
  seven_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NEXT_EVAL && !eq && is_seven) |=> lose);

  // R6
  later_flags_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NEXT_EVAL && !eq && !is_seven) |=> (!win && !lose));

endmodule

// File: rtl/craps_ctrl.sv
module craps_ctrl #(
  parameter int SUM_W       = 4,
  parameter int TALLY_W     = 4,
  parameter int TALLY_MAX   = 9,
  parameter int SYNC_STAGES = 2,
  parameter bit TALLY_EN    = 1'b1
) (
  input  logic               clk,
  input  logic               sys_rst_n,
  input  logic               game_rst_n,
  input  logic               roll_btn,
  input  logic [SUM_W-1:0]   dice_sum,
  input  logic               sum_seven,
  input  logic               sum_natural,
  input  logic               sum_craps,
  output logic               roll_en,
  output logic               store_pt,
  output logic               win,
  output logic               lose,
  output logic [TALLY_W-1:0] win_count,
  output logic [TALLY_W-1:0] loss_count
);

  logic game_arst_n;
  logic game_srst_n;
  logic sys_srst_n;
  logic eq;
  logic win_evt;
  logic lose_evt;

  assign game_arst_n = game_rst_n && sys_rst_n;

  craps_rst_sync #(.STAGES(SYNC_STAGES)) u_game_sync (
    .clk    (clk),
    .arst_n (game_arst_n),
    .srst_n (game_srst_n)
  );

  craps_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk    (clk),
    .arst_n (sys_rst_n),
    .srst_n (sys_srst_n)
  );

  craps_point_reg #(.SUM_W(SUM_W)) u_point (
    .clk   (clk),
    .rst_n (game_srst_n),
    .load  (store_pt),
    .sum   (dice_sum),
    .eq    (eq)
  );

  craps_fsm u_fsm (
    .clk      (clk),
    .rst_n    (game_srst_n),
    .roll_btn (roll_btn),
    .is_nat   (sum_natural),
    .is_craps (sum_craps),
    .is_seven (sum_seven),
    .eq       (eq),
    .roll_en  (roll_en),
    .store_pt (store_pt),
    .win      (win),
    .lose     (lose),
    .win_evt  (win_evt),
    .lose_evt (lose_evt)
  );

  if (TALLY_EN) begin : g_tally
    craps_tally #(.W(TALLY_W), .MAX(TALLY_MAX)) u_wins (
      .clk   (clk),
      .rst_n (sys_srst_n),
      .inc   (win_evt),
      .cnt   (win_count)
    );
    craps_tally #(.W(TALLY_W), .MAX(TALLY_MAX)) u_losses (
      .clk   (clk),
      .rst_n (sys_srst_n),
      .inc   (lose_evt),
      .cnt   (loss_count)
    );
  end else begin : g_no_tally
    assign win_count  = '0;
    assign loss_count = '0;
  end

  // R7
  roll_gate_chk: assert property (@(posedge clk) disable iff (!game_srst_n)
    roll_en |-> roll_btn);

  // R8
  result_excl_chk: assert property (@(posedge clk) disable iff (!game_srst_n)
    !(win && lose));

  // R8
  win_hold_chk: assert property (@(posedge clk) disable iff (!game_srst_n)
    win |=> win);

  // R8
  lose_hold_chk: assert property (@(posedge clk) disable iff (!game_srst_n)
    lose |=> lose);

  // R3
  store_pulse_chk: assert property (@(posedge clk) disable iff (!game_srst_n)
    store_pt |=> (!store_pt && !win && !lose));

endmodule

// File: tb/tb_craps_ctrl.sv
module tb_craps_ctrl;

  logic       clk = 1'b0;
  logic       sys_rst_n, game_rst_n, roll_btn;
  logic [3:0] dice_sum;
  logic       sum_seven, sum_natural, sum_craps;
  logic       roll_en, store_pt, win, lose;
  logic [3:0] win_count, loss_count;

  int n_run  = 0;
  int n_fail = 0;
  int exp_w  = 0;
  int exp_l  = 0;

  always #5 clk = ~clk;

  craps_ctrl dut (
    .clk(clk), .sys_rst_n(sys_rst_n), .game_rst_n(game_rst_n),
    .roll_btn(roll_btn), .dice_sum(dice_sum), .sum_seven(sum_seven),
    .sum_natural(sum_natural), .sum_craps(sum_craps), .roll_en(roll_en),
    .store_pt(store_pt), .win(win), .lose(lose),
    .win_count(win_count), .loss_count(loss_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_sum(input int s);
    dice_sum    = 4'(s);
    sum_seven   = (s == 7);
    sum_natural = (s == 7) || (s == 11);
    sum_craps   = (s == 2) || (s == 3) || (s == 12);
  endtask

  // Press, hold, release; returns store_pt in the evaluation cycle and the result after it.
  task automatic roll(input int s, output logic st, output logic w, output logic l);
    @(negedge clk);
    set_sum(s);
    roll_btn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 roll_en while held", int'(roll_en), 1);
    roll_btn = 1'b0;
    @(negedge clk);
    st = store_pt;
    chk("R7 roll_en in evaluation", int'(roll_en), 0);
    @(negedge clk);
    w = win;
    l = lose;
  endtask

  task automatic counts_chk(input string req);
    chk({req, " win_count"}, int'(win_count), exp_w);
    chk({req, " loss_count"}, int'(loss_count), exp_l);
  endtask

  task automatic sys_reset();
    @(negedge clk);
    sys_rst_n = 1'b0;
    #1;
    chk("R11 counts cleared at once", int'(win_count) + int'(loss_count), 0);
    repeat (2) @(negedge clk);
    sys_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_w = 0;
    exp_l = 0;
  endtask

  task automatic game_reset();
    @(negedge clk);
    game_rst_n = 1'b0;
    #1;
    chk("R9 win cleared without clock", int'(win), 0);
    chk("R9 lose cleared without clock", int'(lose), 0);
    chk("R9 store_pt cleared", int'(store_pt), 0);
    repeat (2) @(negedge clk);
    game_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    sys_reset();
    chk("R11 win after reset", int'(win), 0);
    chk("R11 lose after reset", int'(lose), 0);
    chk("R11 store_pt after reset", int'(store_pt), 0);
    chk("R7 roll_en idle", int'(roll_en), 0);
    counts_chk("R11 after reset");
  endtask

  task automatic t_open_win(input int s);
    logic st, w, l;
    game_reset();
    roll(s, st, w, l);
    exp_w++;
    chk($sformatf("R1 open %0d win", s), int'(w), 1);
    chk($sformatf("R1 open %0d lose", s), int'(l), 0);
    chk($sformatf("R1 open %0d no store", s), int'(st), 0);
    counts_chk("R10 after win");
  endtask

  task automatic t_open_lose(input int s);
    logic st, w, l;
    game_reset();
    roll(s, st, w, l);
    exp_l++;
    chk($sformatf("R2 open %0d lose", s), int'(l), 1);
    chk($sformatf("R2 open %0d win", s), int'(w), 0);
    counts_chk("R10 after loss");
  endtask

  task automatic t_point_win();
    logic st, w, l;
    game_reset();
    roll(6, st, w, l);
    chk("R3 store strobe on point 6", int'(st), 1);
    chk("R3 no result on point", int'(w) + int'(l), 0);
    @(negedge clk);
    chk("R3 strobe one cycle", int'(store_pt), 0);
    roll(8, st, w, l);
    chk("R5 plain follow-up continues", int'(w) + int'(l), 0);
    chk("R5 no store on follow-up", int'(st), 0);
    roll(11, st, w, l);
    chk("R6 later 11 ignored", int'(w) + int'(l), 0);
    roll(2, st, w, l);
    chk("R6 later 2 ignored", int'(w) + int'(l), 0);
    roll(6, st, w, l);
    exp_w++;
    chk("R4 point made win", int'(w), 1);
    chk("R4 point made lose", int'(l), 0);
    counts_chk("R10 point win");
  endtask

  task automatic t_point_lose();
    logic st, w, l;
    game_reset();
    roll(4, st, w, l);
    chk("R3 store strobe on point 4", int'(st), 1);
    roll(10, st, w, l);
    chk("R5 follow-up 10 continues", int'(w) + int'(l), 0);
    roll(7, st, w, l);
    exp_l++;
    chk("R5 seven-out lose", int'(l), 1);
    chk("R5 seven-out win", int'(w), 0);
    counts_chk("R10 seven-out");
  endtask

  task automatic t_terminal_hold();
    logic st, w, l;
    game_reset();
    roll(11, st, w, l);
    exp_w++;
    @(negedge clk);
    set_sum(2);
    roll_btn = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 roll_en off after game end", int'(roll_en), 0);
    roll_btn = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 win holds over press", int'(win), 1);
    chk("R8 lose stays low", int'(lose), 0);
    counts_chk("R8 press in end state");
  endtask

  task automatic t_reset_midgame();
    logic st, w, l;
    game_reset();
    roll(5, st, w, l);
    game_reset();
    roll(5, st, w, l);
    chk("R9 next roll is opening roll", int'(st), 1);
    chk("R9 no result", int'(w) + int'(l), 0);
  endtask

  task automatic t_saturate();
    logic st, w, l;
    for (int i = 0; i < 10; i++) begin
      game_reset();
      roll(7, st, w, l);
      if (exp_w < 9) exp_w++;
    end
    chk("R10 win_count saturates at 9", int'(win_count), 9);
    game_reset();
    counts_chk("R10 game reset keeps counts");
    for (int i = 0; i < 10; i++) begin
      game_reset();
      roll(12, st, w, l);
      if (exp_l < 9) exp_l++;
    end
    chk("R10 loss_count saturates at 9", int'(loss_count), 9);
  endtask

  task automatic t_open_seven_flag();
    logic st, w, l;
    game_reset();
    @(negedge clk);
    roll(9, st, w, l);
    chk("R6 opening 9 stores point", int'(st), 1);
    chk("R6 opening 9 undecided", int'(w) + int'(l), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    sys_rst_n  = 1'b0;
    game_rst_n = 1'b1;
    roll_btn   = 1'b0;
    set_sum(2);
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_open_win(7);
    t_open_win(11);
    t_open_lose(2);
    t_open_lose(3);
    t_open_lose(12);
    t_point_win();
    t_point_lose();
    t_terminal_hold();
    t_reset_midgame();
    t_open_seven_flag();
    t_saturate();
    sys_reset();
    counts_chk("R11 sys reset clears counts");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule